// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte a host sees when it reads a memory device while an internal program or erase operation is running. While an operation is active, or after one has failed, each read strobe returns a status byte instead of array contents. The status byte carries five flags:

- a polling bit, which reads opposite to the final value until the operation completes;
- a bit that flips on every status read;
- a time-limit failure flag;
- a failure-location flag;
- an erase-started flag.

Once an operation finishes normally, reads return array data again. A failed operation keeps the block in status reporting until a reset command is written.

The host polls the same address repeatedly. It decides that the operation is complete when the polling bit matches the value it expects, or when the toggling bit stops flipping. It uses the failure flags to abandon the operation and issue a reset command. The operation sequencer drives the busy, type, window and time-out inputs. The array supplies the read data.

Top module: `op_status_reporter`

## Requirements
- R1: During a program operation (`busy_i`=1, `op_erase_i`=0), a status read returns bit 7 equal to the inverse of `prog_d7_i`.
- R2: During an erase operation (`busy_i`=1, `op_erase_i`=1), a status read returns bit 7 as 0.
- R3: Bit 6 of a status read holds a toggle flag. After reset the flag is 0, and it inverts after every status read. Reads in array mode do not change it.
- R4: Bit 5 becomes 1 once `timeout_i` is seen while `busy_i` is 1. From then on every read returns status, even after `busy_i` falls, until `reset_cmd_i` is seen. `timeout_i` while idle has no effect, and `reset_cmd_i` with no failure pending has no effect.
- R5: While bit 5 is 1, bit 4 gives the failed operation type: 0 for program and 1 for erase. Bit 4 is 0 when there is no failure.
- R6: For an erase, bit 3 is 0 while `win_open_i`=1 and 1 once the window has closed. For a program, bit 3 is 0. A failed erase reports bit 3 as 1.
- R7: In a status byte, bits 2 to 0 and all bits above bit 7 are 0.
- R8: With no operation active and no failure pending, a read returns `array_i` as sampled at the strobe edge. The result appears on the cycle after the strobe. `rd_data_o` holds its value between strobes.
- R9: After a synchronous reset, `rd_data_o` is 0, `rd_valid_o` is 0 and no failure is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | An internal program or erase operation is running |
| op_erase_i | input | 1 | Operation type: 1 erase, 0 program |
| prog_d7_i | input | 1 | Bit 7 of the byte being programmed |
| timeout_i | input | 1 | Time limit of the running operation exceeded |
| win_open_i | input | 1 | Sector-erase acceptance window still open |
| reset_cmd_i | input | 1 | Reset command written by the host |
| rd_i | input | 1 | Read strobe |
| array_i | input | DATA_W | Array read data |
| rd_data_o | output | DATA_W | Registered read data: status byte or array data |
| rd_valid_o | output | 1 | `rd_data_o` was updated by the previous strobe |

## Verification
The hardest state to reach is a pending failure after `busy_i` has dropped. The bench raises `timeout_i` during an erase and then during a program, releases `busy_i`, and keeps reading with changed array data. This shows that status persists, that it records the right failure location and latched operation type, and that only `reset_cmd_i` restores array reads. The toggle bit depends on the full history of status reads, so the bench keeps its own toggle model across all operations.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned FAIL_BIT = 5;
  localparam int unsigned LOC_BIT  = 4;
  localparam int unsigned RUN_BIT  = 3;

  typedef enum logic {OP_PROGRAM = 1'b0, OP_ERASE = 1'b1} op_kind_e;
endpackage

// File: rtl/fail_tracker.sv
module fail_tracker (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic op_erase_i,
  input  logic timeout_i,
  input  logic reset_cmd_i,
  output logic fail_o,
  output logic fail_erase_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fail_o       <= 1'b0;
      fail_erase_o <= 1'b0;
    end else if (reset_cmd_i) begin
      fail_o       <= 1'b0;
      fail_erase_o <= 1'b0;
    end else if (busy_i && timeout_i && !fail_o) begin
      fail_o       <= 1'b1;
      fail_erase_o <= op_erase_i;
    end
  end

  // R4: failure stays until a reset command
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !reset_cmd_i) |=> fail_o);
  // R4: reset command clears the failure
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    reset_cmd_i |=> !fail_o);
endmodule

// File: rtl/toggle_gen.sv
module toggle_gen (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic tog_o
);
  always_ff @(posedge clk) begin
    if (rst)        tog_o <= 1'b0;
    else if (adv_i) tog_o <= ~tog_o;
  end

  // R3: no status read, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(tog_o));
endmodule

// File: rtl/status_mux.sv
module status_mux
  import op_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              op_erase_i,
  input  logic              d7_i,
  input  logic              tog_i,
  input  logic              fail_i,
  input  logic              fail_erase_i,
  input  logic              erase_run_i,
  output logic [DATA_W-1:0] status_o
);
  always_comb begin
    status_o           = '0;
    status_o[POLL_BIT] = (op_kind_e'(op_erase_i) == OP_ERASE) ? 1'b0 : ~d7_i;
    status_o[TOG_BIT]  = tog_i;
    status_o[FAIL_BIT] = fail_i;
    status_o[LOC_BIT]  = fail_i & fail_erase_i;
    status_o[RUN_BIT]  = erase_run_i;
  end
endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter
  import op_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic              prog_d7_i,
  input  logic              timeout_i,
  input  logic              win_open_i,
  input  logic              reset_cmd_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic              fail_q, fail_erase_q, tog_q;
  logic              op_q, d7_q;
  logic              op_sel, d7_sel, status_mode, erase_run;
  logic [DATA_W-1:0] status_byte;

  // keep operation attributes for reporting after busy falls
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= 1'b0;
      d7_q <= 1'b0;
    end else if (busy_i) begin
      op_q <= op_erase_i;
      d7_q <= prog_d7_i;
    end
  end

  assign op_sel      = busy_i ? op_erase_i : op_q;
  assign d7_sel      = busy_i ? prog_d7_i  : d7_q;
  assign status_mode = busy_i | fail_q;
  assign erase_run   = op_sel & ~(busy_i & win_open_i);

  fail_tracker u_fail (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (busy_i),
    .op_erase_i   (op_erase_i),
    .timeout_i    (timeout_i),
    .reset_cmd_i  (reset_cmd_i),
    .fail_o       (fail_q),
    .fail_erase_o (fail_erase_q)
  );

  toggle_gen u_tog (
    .clk   (clk),
    .rst   (rst),
    .adv_i (rd_i & status_mode),
    .tog_o (tog_q)
  );

  status_mux #(.DATA_W(DATA_W)) u_mux (
    .op_erase_i   (op_sel),
    .d7_i         (d7_sel),
    .tog_i        (tog_q),
    .fail_i       (fail_q),
    .fail_erase_i (fail_erase_q),
    .erase_run_i  (erase_run),
    .status_o     (status_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= status_mode ? status_byte : array_i;
    end
  end

  // R1: program polling returns inverted bit 7
  a_r1_prog_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_i && !op_erase_i) |=> rd_data_o[POLL_BIT] == !$past(prog_d7_i));
  // R2: erase polling returns 0 on bit 7
  a_r2_erase_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_i && op_erase_i) |=> !rd_data_o[POLL_BIT]);
  // R3: consecutive-cycle status reads differ in bit 6
  a_r3_flip: assert property (@(posedge clk) disable iff (rst)
    (rd_i && status_mode && $past(rd_i && status_mode) && !$past(rst)) |=>
      rd_data_o[TOG_BIT] != $past(rd_data_o[TOG_BIT]));
  // R7: low status bits are zero
  a_r7_low_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && status_mode) |=> rd_data_o[2:0] == 3'b000);
  // R8: array data passes through in read mode
  a_r8_array: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !status_mode) |=> rd_data_o == $past(array_i));
  // R8: output holds between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: tb/tb_op_status_reporter.sv
module tb_op_status_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_i = 0, op_erase_i = 0, prog_d7_i = 0, timeout_i = 0;
  logic win_open_i = 0, reset_cmd_i = 0, rd_i = 0;
  logic [DATA_W-1:0] array_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic rd_valid_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];

  // bench model
  bit tog_m = 0, fail_m = 0, fail_er_m = 0, op_m = 0, d7_m = 0;

  op_status_reporter #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .busy_i(busy_i), .op_erase_i(op_erase_i),
    .prog_d7_i(prog_d7_i), .timeout_i(timeout_i), .win_open_i(win_open_i),
    .reset_cmd_i(reset_cmd_i), .rd_i(rd_i), .array_i(array_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_byte();
    logic [DATA_W-1:0] b;
    bit op, d7;
    b = '0;
    op = busy_i ? op_erase_i : op_m;
    d7 = busy_i ? prog_d7_i : d7_m;
    if (busy_i || fail_m) begin
      b[7] = op ? 1'b0 : ~d7;
      b[6] = tog_m;
      b[5] = fail_m;
      b[4] = fail_m & fail_er_m;
      b[3] = op & ~(busy_i & win_open_i);
    end else begin
      b = array_i;
    end
    return b;
  endfunction

  // one clock cycle with the inputs currently driven
  task automatic cyc(input bit rd, input string tag);
    bit st;
    st = busy_i || fail_m;
    rd_i = rd;
    if (rd) begin
      exp_q.push_back(model_byte());
      tag_q.push_back(tag);
    end
    @(posedge clk);
    if (rd && st) tog_m = ~tog_m;
    if (reset_cmd_i) begin
      fail_m = 0; fail_er_m = 0;
    end else if (busy_i && timeout_i && !fail_m) begin
      fail_m = 1; fail_er_m = op_erase_i;
    end
    if (busy_i) begin
      op_m = op_erase_i; d7_m = prog_d7_i;
    end
    @(negedge clk);
    rd_i = 0; timeout_i = 0; reset_cmd_i = 0;
  endtask

  // monitor: compare each registered read result
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual %h expected no result", rd_data_o);
      end else begin
        check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    check("R9 data", rd_data_o, '0);
    check("R9 valid", {7'b0, rd_valid_o}, 8'h00);

    // R8 array read and hold
    array_i = 8'hA5;
    cyc(1, "R8 array");
    array_i = 8'h3C;
    cyc(0, "");
    check("R8 hold", rd_data_o, 8'hA5);
    cyc(1, "R8 array2");

    // R1 R3 R7 program, d7=1
    busy_i = 1; op_erase_i = 0; prog_d7_i = 1;
    cyc(1, "R1 prog poll");
    cyc(1, "R3 toggle");
    cyc(0, "");
    cyc(1, "R7 status low bits");
    busy_i = 0; array_i = 8'h80;
    cyc(1, "R8 after program");
    cyc(1, "R3 no toggle in array mode");

    // R1 d7=0
    busy_i = 1; prog_d7_i = 0; array_i = 8'h11;
    cyc(1, "R1 prog poll d7=0");
    busy_i = 0;
    cyc(1, "R8 back to array");

    // R2 R6 sector erase with window
    busy_i = 1; op_erase_i = 1; win_open_i = 1;
    cyc(1, "R6 window open");
    cyc(1, "R2 erase poll");
    win_open_i = 0;
    cyc(1, "R6 erase started");

    // R4 R5 erase failure
    timeout_i = 1;
    cyc(0, "");
    busy_i = 0; array_i = 8'hFF;
    cyc(1, "R4 sticky after busy drop");
    array_i = 8'h12;
    cyc(1, "R5 erase location");
    reset_cmd_i = 1;
    cyc(0, "");
    cyc(1, "R4 reset command restores array");

    // R5 program failure
    busy_i = 1; op_erase_i = 0; prog_d7_i = 1;
    cyc(0, "");
    timeout_i = 1;
    cyc(1, "R1 prog poll at timeout");
    busy_i = 0; array_i = 8'h77;
    cyc(1, "R5 program location");
    cyc(1, "R6 program bit3 zero");
    reset_cmd_i = 1;
    cyc(1, "R4 read in reset cycle");
    cyc(1, "R4 array after reset");

    // R4 idle timeout and idle reset command ignored
    timeout_i = 1; array_i = 8'h5A;
    cyc(0, "");
    cyc(1, "R4 idle timeout ignored");
    reset_cmd_i = 1;
    cyc(1, "R4 idle reset command");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R8: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule